// File: doc/BRIEF.md
# Performance Monitor Counter CSR Unit

This unit is one hardware performance-monitor counter slot together with the control-register access logic that serves it. It keeps a 64-bit count and a small selector register. Each cycle a vector of event pulses comes from the pipeline, and the selector picks which pulse advances the count. Machine software can stop the count with a per-counter inhibit bit. It can also let lower-privilege software read a read-only shadow copy of the count through a per-counter enable bit.

The unit connects to a plain CSR port. The port carries a 12-bit address, read and write strobes, write data and the current privilege level. The unit answers in the same cycle with read data and an illegal-access flag. Writes take effect at the next clock edge. On a 32-bit core (`XLEN = 32`), the count is reached through a low and a high address pair. On a 64-bit core, the full count sits behind one address. With `IMPLEMENTED = 0`, the counter is hard-wired to zero.

Top module: `hpmCounterUnit`

## Requirements
- R1: After reset, the count, the selector, the inhibit bit and the enable bit are all zero, so every readable register reads 0.
- R2: In each cycle where the inhibit bit is 0, the selector value s is non-zero and `eventPulse[s]` is 1, the count advances by exactly one. Selector 0 never counts, and pulses on other bits have no effect.
- R3: While the inhibit bit (bit 5 of address 0x320) is 1, the count holds its value.
- R4: A machine-mode write to 0x B05 replaces the count with the write data. With `XLEN = 32` it replaces only bits 31:0 and leaves bits 63:32 unchanged.
- R5: With `XLEN = 32`, addresses 0xB85 (machine) and 0xC85 (shadow) read bits 63:32 of the count, and a machine-mode write to 0xB85 replaces bits 63:32.
- R6: When a legal count write and a counted event fall in the same cycle, the written value is kept and that cycle's increment is dropped.
- R7: An access to 0xB05, 0xB85, 0x325, 0x320 or 0x306 at a privilege other than machine (`privLevel` 2'b11) raises `csrIllegal`, returns 0 and changes no state.
- R8: A read of shadow address 0xC05 is legal in machine mode. At a lower privilege it is legal only while the enable bit (bit 5 of 0x306) is 1; otherwise it raises `csrIllegal` and returns 0.
- R9: Any write to a shadow address raises `csrIllegal` and leaves the count unchanged.
- R10: An address that the unit does not hold raises `csrIllegal` on access. This includes 0xB85 and 0xC85 when `XLEN = 64`. With `IMPLEMENTED = 0`, the count reads 0 and never changes.
- R11: The selector at 0x325 stores the low `$clog2(NUM_EVENTS)` bits of the write data and reads back zero-extended. `csrRdata` is 0 in any cycle without a legal read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrAddr | input | 12 | CSR address |
| csrRead | input | 1 | Read strobe |
| csrWrite | input | 1 | Write strobe |
| csrWdata | input | XLEN | Write data |
| privLevel | input | 2 | Current privilege, 2'b11 is machine |
| eventPulse | input | NUM_EVENTS | Per-cycle event pulses, bit 0 unused |
| csrRdata | output | XLEN | Read data, 0 without a legal read |
| csrIllegal | output | 1 | Access is not permitted |

## Verification
The bench targets several corner cases, and each has a visible failure signature:
- **Write and event in the same cycle.** A design that lets the increment win reads one above the written value.
- **Carry from the low half into the high half.** A design with a 32-bit counter shows a frozen high word.
- **Low-half write on a 32-bit core.** A design that clears bits 63:32 loses the high word.
- **Shadow access.** A design that ignores the enable bit leaks the count to user mode, and one that accepts shadow writes corrupts the count.
- **Selector zero.** Treating bit 0 as a real event makes the count advance.
- **Unimplemented counter.** A second, 64-bit instance with no counter checks that the count reads zero and that the high alias is rejected.

// File: rtl/hpmPkg.sv
package hpmPkg;
  localparam logic [11:0] ADDR_M_LO = 12'hB05;
  localparam logic [11:0] ADDR_M_HI = 12'hB85;
  localparam logic [11:0] ADDR_S_LO = 12'hC05;
  localparam logic [11:0] ADDR_S_HI = 12'hC85;
  localparam logic [11:0] ADDR_SEL  = 12'h325;
  localparam logic [11:0] ADDR_INH  = 12'h320;
  localparam logic [11:0] ADDR_EN   = 12'h306;
  localparam int          SLOT_BIT  = 5;
  localparam logic [1:0]  PRIV_M    = 2'b11;

  typedef enum logic [2:0] {
    RD_NONE, RD_CNT_LO, RD_CNT_HI, RD_SEL, RD_INH, RD_EN
  } rdSel_e;

  typedef struct packed {
    logic   wrCntLo;
    logic   wrCntHi;
    logic   wrSel;
    logic   wrInh;
    logic   wrEn;
    rdSel_e rdSel;
  } hpmStrobe_t;
endpackage

// File: rtl/hpmCtrl.sv
module hpmCtrl
  import hpmPkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [11:0]      csrAddr,
  input  logic             csrRead,
  input  logic             csrWrite,
  input  logic [1:0]       privLevel,
  input  logic             enableBit,
  output hpmStrobe_t       strobe,
  output logic             csrIllegal
);
  localparam bit HAS_HI = (XLEN == 32);

  typedef enum logic [2:0] {
    REG_NONE, REG_M_LO, REG_M_HI, REG_S_LO, REG_S_HI, REG_SEL, REG_INH, REG_EN
  } region_e;

  region_e region;
  logic    isMachine;
  logic    access;
  logic    legal;
  logic    okWrite;

  always_comb begin
    region = REG_NONE;
    case (csrAddr)
      ADDR_M_LO: region = REG_M_LO;
      ADDR_M_HI: region = HAS_HI ? REG_M_HI : REG_NONE;
      ADDR_S_LO: region = REG_S_LO;
      ADDR_S_HI: region = HAS_HI ? REG_S_HI : REG_NONE;
      ADDR_SEL:  region = REG_SEL;
      ADDR_INH:  region = REG_INH;
      ADDR_EN:   region = REG_EN;
      default:   region = REG_NONE;
    endcase
  end

  assign isMachine = (privLevel == PRIV_M);
  assign access    = csrRead | csrWrite;

  always_comb begin
    case (region)
      REG_M_LO, REG_M_HI, REG_SEL, REG_INH, REG_EN: legal = isMachine;
      REG_S_LO, REG_S_HI: legal = !csrWrite && (isMachine || enableBit);
      default: legal = 1'b0;
    endcase
  end

  assign csrIllegal = access && !legal;
  assign okWrite    = csrWrite && legal;

  always_comb begin
    strobe.wrCntLo = okWrite && (region == REG_M_LO);
    strobe.wrCntHi = okWrite && (region == REG_M_HI);
    strobe.wrSel   = okWrite && (region == REG_SEL);
    strobe.wrInh   = okWrite && (region == REG_INH);
    strobe.wrEn    = okWrite && (region == REG_EN);
    strobe.rdSel   = RD_NONE;
    if (csrRead && legal) begin
      case (region)
        REG_M_LO, REG_S_LO: strobe.rdSel = RD_CNT_LO;
        REG_M_HI, REG_S_HI: strobe.rdSel = RD_CNT_HI;
        REG_SEL:            strobe.rdSel = RD_SEL;
        REG_INH:            strobe.rdSel = RD_INH;
        REG_EN:             strobe.rdSel = RD_EN;
        default:            strobe.rdSel = RD_NONE;
      endcase
    end
  end

  AST_ILLEGAL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    csrIllegal |-> ($countones({strobe.wrCntLo, strobe.wrCntHi, strobe.wrSel,
                                strobe.wrInh, strobe.wrEn}) == 0
                    && strobe.rdSel == RD_NONE)); // R7
  AST_LOWPRIV_MACHINE: assert property (@(posedge clk) disable iff (!rstN)
    (access && privLevel != PRIV_M && csrAddr == ADDR_M_LO) |-> csrIllegal); // R7
  AST_SHADOW_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (csrRead && privLevel != PRIV_M && csrAddr == ADDR_S_LO && !enableBit)
      |-> csrIllegal); // R8
  AST_SHADOW_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrite && (csrAddr == ADDR_S_LO || csrAddr == ADDR_S_HI)) |-> csrIllegal); // R9
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrCntLo, strobe.wrCntHi, strobe.wrSel, strobe.wrInh,
              strobe.wrEn})); // R4
endmodule

// File: rtl/hpmDatapath.sv
module hpmDatapath
  import hpmPkg::*;
#(
  parameter int XLEN        = 32,
  parameter int NUM_EVENTS  = 16,
  parameter bit IMPLEMENTED = 1'b1,
  parameter int SEL_W       = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  hpmStrobe_t            strobe,
  input  logic [XLEN-1:0]       wrData,
  input  logic [NUM_EVENTS-1:0] eventPulse,
  output logic [XLEN-1:0]       rdData,
  output logic                  enableBit
);
  localparam int PAD_W = 1 << SEL_W;

  logic [63:0]      countQ;
  logic [63:0]      countD;
  logic [SEL_W-1:0] selQ;
  logic             inhQ;
  logic             enQ;
  logic [PAD_W-1:0] evPad;
  logic             evHit;
  logic             cntWrite;

  assign evPad    = PAD_W'(eventPulse);
  assign evHit    = !inhQ && (selQ != '0) && evPad[selQ];
  assign cntWrite = strobe.wrCntLo | strobe.wrCntHi;

  generate
    if (XLEN == 32) begin : g_split
      always_comb begin
        countD = countQ;
        if (strobe.wrCntLo)      countD[31:0]  = wrData[31:0];
        else if (strobe.wrCntHi) countD[63:32] = wrData[31:0];
        else if (evHit)          countD        = countQ + 64'd1;
      end
    end else begin : g_full
      always_comb begin
        countD = countQ;
        if (strobe.wrCntLo) countD = 64'(wrData);
        else if (evHit)     countD = countQ + 64'd1;
      end
    end

    if (IMPLEMENTED) begin : g_cnt
      always_ff @(posedge clk) begin
        if (!rstN) countQ <= '0;
        else       countQ <= countD;
      end
    end else begin : g_nocnt
      assign countQ = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0;
      inhQ <= 1'b0;
      enQ  <= 1'b0;
    end else begin
      if (strobe.wrSel) selQ <= wrData[SEL_W-1:0];
      if (strobe.wrInh) inhQ <= wrData[SLOT_BIT];
      if (strobe.wrEn)  enQ  <= wrData[SLOT_BIT];
    end
  end

  assign enableBit = enQ;

  always_comb begin
    case (strobe.rdSel)
      RD_CNT_LO: rdData = countQ[XLEN-1:0];
      RD_CNT_HI: rdData = XLEN'(countQ >> 32);
      RD_SEL:    rdData = XLEN'(selQ);
      RD_INH:    rdData = XLEN'(inhQ) << SLOT_BIT;
      RD_EN:     rdData = XLEN'(enQ) << SLOT_BIT;
      default:   rdData = '0;
    endcase
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    !cntWrite |=> (countQ == $past(countQ) || countQ == $past(countQ) + 64'd1)); // R2
  AST_ZERO_SEL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (selQ == '0 && !cntWrite) |=> $stable(countQ)); // R2
  AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (inhQ && !cntWrite) |=> $stable(countQ)); // R3

  generate
    if (IMPLEMENTED && XLEN == 32) begin : g_ast32
      AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
        strobe.wrCntLo |=> countQ[31:0] == $past(wrData[31:0])); // R6
      AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rstN)
        strobe.wrCntLo |=> countQ[63:32] == $past(countQ[63:32])); // R4
    end else if (IMPLEMENTED) begin : g_ast64
      AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
        strobe.wrCntLo |=> countQ == 64'($past(wrData))); // R6
    end else begin : g_astOff
      AST_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> countQ == '0 && $stable(countQ)); // R10
    end
  endgenerate
endmodule

// File: rtl/hpmCounterUnit.sv
module hpmCounterUnit
  import hpmPkg::*;
#(
  parameter int XLEN        = 32,
  parameter int NUM_EVENTS  = 16,
  parameter bit IMPLEMENTED = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [11:0]           csrAddr,
  input  logic                  csrRead,
  input  logic                  csrWrite,
  input  logic [XLEN-1:0]       csrWdata,
  input  logic [1:0]            privLevel,
  input  logic [NUM_EVENTS-1:0] eventPulse,
  output logic [XLEN-1:0]       csrRdata,
  output logic                  csrIllegal
);
  localparam int SEL_W = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1;

  hpmStrobe_t strobe;
  logic       enableBit;

  hpmCtrl #(.XLEN(XLEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrRead(csrRead),
    .csrWrite(csrWrite), .privLevel(privLevel), .enableBit(enableBit),
    .strobe(strobe), .csrIllegal(csrIllegal)
  );

  hpmDatapath #(
    .XLEN(XLEN), .NUM_EVENTS(NUM_EVENTS), .IMPLEMENTED(IMPLEMENTED), .SEL_W(SEL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(csrWdata),
    .eventPulse(eventPulse), .rdData(csrRdata), .enableBit(enableBit)
  );
endmodule

// File: tb/hpmCounterUnit_test.sv
module hpmCounterUnit_test;
  localparam int NEV = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [11:0]     csrAddr = '0;
  logic            csrRead = 1'b0;
  logic            csrWrite = 1'b0;
  logic [31:0]     csrWdata = '0;
  logic [1:0]      privLevel = 2'b11;
  logic [NEV-1:0]  eventPulse = '0;
  logic [31:0]     csrRdata;
  logic            csrIllegal;
  logic [63:0]     offRdata;
  logic            offIllegal;

  int checks = 0;
  int fails  = 0;

  logic [63:0] mCount = '0;
  logic [3:0]  mSel = '0;
  logic        mInh = 1'b0;
  logic        mEn  = 1'b0;

  always #4 clk = ~clk;

  hpmCounterUnit #(.XLEN(32), .NUM_EVENTS(NEV), .IMPLEMENTED(1'b1)) uut (
    .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrRead(csrRead),
    .csrWrite(csrWrite), .csrWdata(csrWdata), .privLevel(privLevel),
    .eventPulse(eventPulse), .csrRdata(csrRdata), .csrIllegal(csrIllegal)
  );

  hpmCounterUnit #(.XLEN(64), .NUM_EVENTS(NEV), .IMPLEMENTED(1'b0)) uutOff (
    .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrRead(csrRead),
    .csrWrite(csrWrite), .csrWdata({32'h0, csrWdata}), .privLevel(privLevel),
    .eventPulse(eventPulse), .csrRdata(offRdata), .csrIllegal(offIllegal)
  );

  function automatic bit modelLegal(logic [11:0] a, bit wr, logic [1:0] p);
    bit m = (p == 2'b11);
    case (a)
      12'hB05, 12'hB85, 12'h325, 12'h320, 12'h306: return m;
      12'hC05, 12'hC85: return !wr && (m || mEn);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] modelRead(logic [11:0] a);
    case (a)
      12'hB05, 12'hC05: return mCount[31:0];
      12'hB85, 12'hC85: return mCount[63:32];
      12'h325: return {28'h0, mSel};
      12'h320: return 32'(mInh) << 5;
      12'h306: return 32'(mEn) << 5;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic [11:0] a, bit rd, bit wr, logic [31:0] wd,
                      logic [1:0] p, logic [NEV-1:0] ev);
    bit ok;
    logic [31:0] expRd;
    bit hit;
    @(negedge clk);
    csrAddr = a; csrRead = rd; csrWrite = wr; csrWdata = wd;
    privLevel = p; eventPulse = ev;
    #1;
    ok = modelLegal(a, wr, p);
    expRd = (rd && ok) ? modelRead(a) : 32'h0;
    if (rd || wr) check({tag, " illegal"}, 64'(csrIllegal), 64'((rd || wr) && !ok));
    check({tag, " rdata"}, 64'(csrRdata), 64'(expRd));
    hit = !mInh && (mSel != 0) && ev[mSel];
    @(posedge clk);
    if (wr && ok) begin
      case (a)
        12'hB05: mCount[31:0]  = wd;
        12'hB85: mCount[63:32] = wd;
        12'h325: mSel = wd[3:0];
        12'h320: mInh = wd[5];
        12'h306: mEn  = wd[5];
        default: ;
      endcase
    end
    if (!(wr && ok && (a == 12'hB05 || a == 12'hB85)) && hit) mCount = mCount + 64'd1;
  endtask

  task automatic idle(int n, logic [NEV-1:0] ev);
    for (int i = 0; i < n; i++) step("idle", 12'h000, 0, 0, 0, 2'b11, ev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] addrs [8];
    addrs = '{12'hB05, 12'hB85, 12'hC05, 12'hC85, 12'h325, 12'h320, 12'h306, 12'h123};
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    step("R1 cnt", 12'hB05, 1, 0, 0, 2'b11, '1);
    step("R1 hi",  12'hB85, 1, 0, 0, 2'b11, '1);
    step("R1 sel", 12'h325, 1, 0, 0, 2'b11, '1);
    step("R1 inh", 12'h320, 1, 0, 0, 2'b11, '1);
    step("R1 en",  12'h306, 1, 0, 0, 2'b11, '1);

    // R2 counting on selected event, selector zero idle
    idle(4, 16'hFFFF);
    step("R2 sel0", 12'hB05, 1, 0, 0, 2'b11, '0);
    step("R11 selw", 12'h325, 0, 1, 32'hFFFF_FFF3, 2'b11, '0);
    step("R11 selr", 12'h325, 1, 0, 0, 2'b11, '0);
    idle(5, 16'h0008);
    idle(3, 16'hFFF7);
    step("R2 cnt", 12'hB05, 1, 0, 0, 2'b11, '0);

    // R3 inhibit
    step("R3 set", 12'h320, 0, 1, 32'h20, 2'b11, 16'h0008);
    idle(4, 16'h0008);
    step("R3 hold", 12'hB05, 1, 0, 0, 2'b11, 16'h0008);
    step("R3 clr", 12'h320, 0, 1, 32'h0, 2'b11, 16'h0008);

    // R4 R5 split halves and carry
    step("R5 hiw", 12'hB85, 0, 1, 32'h12, 2'b11, '0);
    step("R4 low", 12'hB05, 0, 1, 32'hFFFF_FFFF, 2'b11, '0);
    step("R5 carry", 12'h000, 0, 0, 0, 2'b11, 16'h0008);
    step("R5 hir", 12'hB85, 1, 0, 0, 2'b11, '0);
    step("R4 lor", 12'hB05, 1, 0, 0, 2'b11, '0);
    step("R4 low2", 12'hB05, 0, 1, 32'h5, 2'b11, '0);
    step("R4 keephi", 12'hB85, 1, 0, 0, 2'b11, '0);

    // R6 write wins over event
    step("R6 wr", 12'hB05, 0, 1, 32'h100, 2'b11, 16'h0008);
    step("R6 rd", 12'hB05, 1, 0, 0, 2'b11, '0);

    // R7 low privilege on machine address
    step("R7 rd", 12'hB05, 1, 0, 0, 2'b00, '0);
    step("R7 wr", 12'hB05, 0, 1, 32'hDEAD, 2'b01, '0);
    step("R7 chk", 12'hB05, 1, 0, 0, 2'b11, '0);

    // R8 shadow gating
    step("R8 off", 12'hC05, 1, 0, 0, 2'b00, '0);
    step("R8 m", 12'hC05, 1, 0, 0, 2'b11, '0);
    step("R8 en", 12'h306, 0, 1, 32'h20, 2'b11, '0);
    step("R8 on", 12'hC05, 1, 0, 0, 2'b00, '0);
    step("R5 shi", 12'hC85, 1, 0, 0, 2'b01, '0);

    // R9 shadow writes
    step("R9 wr", 12'hC05, 0, 1, 32'h77, 2'b11, '0);
    step("R9 chk", 12'hB05, 1, 0, 0, 2'b11, '0);

    // R10 unknown address and unimplemented 64-bit instance
    step("R10 unk", 12'h123, 1, 0, 0, 2'b11, '0);
    @(negedge clk);
    csrAddr = 12'hB05; csrRead = 1; csrWrite = 0; privLevel = 2'b11; eventPulse = '0;
    #1;
    check("R10 off zero", offRdata, 64'h0);
    check("R10 off legal", 64'(offIllegal), 64'h0);
    csrAddr = 12'hB85;
    #1;
    check("R10 off hi", 64'(offIllegal), 64'h1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 9);
      logic [1:0] pv = ($urandom_range(0, 3) == 0) ? 2'b00 : 2'b11;
      logic [11:0] a = addrs[$urandom_range(0, 7)];
      logic [31:0] wd = $urandom();
      if (a == 12'h320 && $urandom_range(0, 3) != 0) wd[5] = 1'b0;
      if (r < 2)      step("R2 rnd", a, 1, 0, wd, pv, NEV'($urandom()));
      else if (r < 3) step("R6 rnd", a, $urandom_range(0, 1) == 1, 1, wd, pv, NEV'($urandom()));
      else            step("R2 ev", 12'h000, 0, 0, 0, pv, NEV'($urandom()));
    end
    step("R2 final", 12'hB05, 1, 0, 0, 2'b11, '0);
    step("R5 final", 12'hB85, 1, 0, 0, 2'b11, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule